// File: doc/BRIEF.md
# Channel-list ADC sequencer

This block is the digital front end of a multiplexed analog-to-digital acquisition path, reached over a 16-bit register bus. Software loads a queue of per-conversion descriptors and enables the two queues. It then starts conversions one at a time by reading a start register. Each descriptor carries a channel number, a gain code, a polarity choice and a single-ended/differential choice.

On each start the sequencer takes the oldest descriptor and presents its fields to an external converter. It pulses a start strobe and waits for the converter's done strobe with a 12-bit code. It flips the code's most significant bit, so that offset-binary becomes two's complement, and queues the result for software to read. A status register reports the queue levels and whether a conversion is in flight. Two interrupt sources are latched as pending flags: result queue reaching half full, and descriptor queue drained. Each flag is gated by its own enable and by a global enable.

Bus map (byte offsets): 0x00 write = control A, read = start; 0x02 write = control B; 0x04 read = status, write = clear pending; 0x10 write = push descriptor, read = pop result.

Top module: `adc_seq_front`

## Requirements
- R1: After reset the status word reads 0x0004, with only the result-empty flag set. `irq` and `cnv_start` are low.
- R2: Control B bit 9 enables the descriptor queue and bit 10 the result queue. While a bit is 0 that queue is held empty and pushes into it are lost. Both bits are 0 after reset.
- R3: With the mode field (control A bits 1:0) equal to 1, a bus read of offset 0x00 pops exactly one descriptor and raises `cnv_start` for one cycle, starting on the edge after the read. During the conversion `cnv_chan`, `cnv_gain`, `cnv_unipolar` and `cnv_diff` show descriptor bits 3:0, 5:4, 6 and 7.
- R4: A start read is ignored when the descriptor queue is empty or the mode field is 0, 2 or 3. No strobe is sent, the active flag stays 0, and the descriptor stays queued.
- R5: A `cnv_done` pulse during a conversion queues `cnv_code` with bit 11 inverted. Reads of offset 0x10 return results in order, in bits 11:0. A read while the result queue is empty returns 0.
- R6: Status bits: 0 conversion active, 1 descriptor queue full, 2 result queue empty, 3 result queue at least half full, 4 result queue full, 12:8 pending flags.
- R7: The descriptor queue holds CL_DEPTH entries. A write to it when full is dropped.
- R8: The result queue holds RES_DEPTH samples and flags half full at RES_DEPTH/2 or more. A result arriving while it is full is dropped.
- R9: A write of control A with mode field 0 during a conversion abandons it. The active flag drops on that edge, and a later `cnv_done` queues nothing.
- R10: Pending bit 8 sets when the result queue becomes half full, and bit 10 sets when the sequencer pops the last descriptor. Any write to offset 0x04 clears all pending bits. `irq` is control A bit 15 AND the OR of pending bits whose enables (control A bits 12:8) are set.
- R11: The descriptor fields on the converter pins stay stable for the whole conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; side effects happen at the edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle the address is presented |
| irq | output | 1 | Interrupt request |
| cnv_start | output | 1 | One-cycle conversion start strobe |
| cnv_chan | output | 4 | Channel number for the converter |
| cnv_gain | output | 2 | Gain code |
| cnv_unipolar | output | 1 | 1 = unipolar range |
| cnv_diff | output | 1 | 1 = differential input |
| cnv_done | input | 1 | Conversion done strobe |
| cnv_code | input | SAMPLE_W (12) | Raw offset-binary converter code |

## Verification
The bench builds the block with CL_DEPTH = 4 and RES_DEPTH = 8, leaving SAMPLE_W at 12. The shallow queues let a few directed conversions fill the descriptor queue, cross the half-full threshold, and drop results at a full result queue. Several distinct descriptor bit patterns check the converter field mapping. The converter model's latency is long enough that an abort write lands before the done strobe.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_SOFT = 2'd1,
        MODE_SCAN = 2'd2,
        MODE_EXT  = 2'd3
    } trig_mode_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } sq_state_e;

    // Descriptor layout is decoded by the converter pins: keep bit order.
    typedef struct packed {
        logic       diff;      // bit 7
        logic       unipolar;  // bit 6
        logic [1:0] gain;      // bits 5:4
        logic [3:0] chan;      // bits 3:0
    } cl_entry_t;

    localparam logic [4:0] OFS_CTRL_A = 5'h00;
    localparam logic [4:0] OFS_CTRL_B = 5'h02;
    localparam logic [4:0] OFS_STAT   = 5'h04;
    localparam logic [4:0] OFS_DATA   = 5'h10;

    localparam int CB_CL_EN  = 9;
    localparam int CB_RES_EN = 10;
    localparam int CA_GLOBAL = 15;
    localparam int PEND_LSB  = 8;
    localparam int NUM_SRC   = 5;
    localparam int SRC_HALF  = 0;
    localparam int SRC_DRAIN = 2;

endpackage

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic                         empty,
    output logic                         full,
    output logic                         half,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign half  = (st_q.cnt >= CW'(DEPTH / 2));
    assign level = st_q.cnt;
    assign rdata = mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> $stable(st_q.cnt));

    assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/adcseq_seq.sv
module adcseq_seq
    import adcseq_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic                abort,
    input  logic                cl_empty,
    input  cl_entry_t           cl_head,
    output logic                cl_pop,
    input  logic                cnv_done,
    input  logic [SAMPLE_W-1:0] cnv_code,
    output logic                res_push,
    output logic [SAMPLE_W-1:0] res_data,
    output logic                cnv_start,
    output cl_entry_t           cnv_entry,
    output logic                active
);
    typedef struct packed {
        sq_state_e state;
        logic      start;
        cl_entry_t entry;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        cl_pop     = 1'b0;
        res_push   = 1'b0;
        unique case (st_q.state)
            SQ_IDLE: begin
                if (start_req && !cl_empty) begin
                    cl_pop     = 1'b1;
                    st_d.state = SQ_BUSY;
                    st_d.start = 1'b1;
                    st_d.entry = cl_head;
                end
            end
            SQ_BUSY: begin
                if (abort) begin
                    st_d.state = SQ_IDLE;
                end else if (cnv_done && !st_q.start) begin
                    res_push   = 1'b1;
                    st_d.state = SQ_IDLE;
                end
            end
            default: st_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_data  = {~cnv_code[SAMPLE_W-1], cnv_code[SAMPLE_W-2:0]};
    assign cnv_start = st_q.start;
    assign cnv_entry = st_q.entry;
    assign active    = (st_q.state == SQ_BUSY);

    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    assert_start_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> active);

    assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(cnv_entry));

    assert_abort_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !active);

endmodule

// File: rtl/adc_seq_front.sv
module adc_seq_front
    import adcseq_pkg::*;
#(
    parameter int CL_DEPTH  = 16,
    parameter int RES_DEPTH = 1024,
    parameter int SAMPLE_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [15:0]         bus_wdata,
    output logic [15:0]         bus_rdata,
    output logic                irq,
    output logic                cnv_start,
    output logic [3:0]          cnv_chan,
    output logic [1:0]          cnv_gain,
    output logic                cnv_unipolar,
    output logic                cnv_diff,
    input  logic                cnv_done,
    input  logic [SAMPLE_W-1:0] cnv_code
);
    localparam int CL_CW  = $clog2(CL_DEPTH + 1);
    localparam int RES_CW = $clog2(RES_DEPTH + 1);

    typedef struct packed {
        trig_mode_e         mode;
        logic [NUM_SRC-1:0] irq_en;
        logic               glob_en;
        logic               cl_en;
        logic               res_en;
        logic [NUM_SRC-1:0] pend;
        logic               half_prev;
    } regs_t;

    regs_t st_d, st_q;

    // bus decode
    logic wr_ca, wr_cb, wr_clr, wr_cl, rd_start, rd_res;
    assign wr_ca    = bus_wr && (bus_addr == OFS_CTRL_A);
    assign wr_cb    = bus_wr && (bus_addr == OFS_CTRL_B);
    assign wr_clr   = bus_wr && (bus_addr == OFS_STAT);
    assign wr_cl    = bus_wr && (bus_addr == OFS_DATA);
    assign rd_start = bus_rd && (bus_addr == OFS_CTRL_A);
    assign rd_res   = bus_rd && (bus_addr == OFS_DATA);

    // queues and sequencer
    logic [7:0]          cl_rdata;
    logic                cl_empty, cl_full, cl_half, cl_pop;
    logic [CL_CW-1:0]    cl_level;
    logic [SAMPLE_W-1:0] res_rdata, res_wdata;
    logic                res_empty, res_full, res_half, res_push;
    logic [RES_CW-1:0]   res_level;
    logic                active, abort, start_req;
    cl_entry_t           cnv_entry;

    assign abort     = wr_ca && (bus_wdata[1:0] == MODE_OFF);
    assign start_req = rd_start && (st_q.mode == MODE_SOFT);

    adcseq_fifo #(.W(8), .DEPTH(CL_DEPTH)) u_cl_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!st_q.cl_en),
        .push  (wr_cl),
        .wdata (bus_wdata[7:0]),
        .pop   (cl_pop),
        .rdata (cl_rdata),
        .empty (cl_empty),
        .full  (cl_full),
        .half  (cl_half),
        .level (cl_level)
    );

    adcseq_fifo #(.W(SAMPLE_W), .DEPTH(RES_DEPTH)) u_res_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!st_q.res_en),
        .push  (res_push),
        .wdata (res_wdata),
        .pop   (rd_res),
        .rdata (res_rdata),
        .empty (res_empty),
        .full  (res_full),
        .half  (res_half),
        .level (res_level)
    );

    adcseq_seq #(.SAMPLE_W(SAMPLE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .abort     (abort),
        .cl_empty  (cl_empty),
        .cl_head   (cl_entry_t'(cl_rdata)),
        .cl_pop    (cl_pop),
        .cnv_done  (cnv_done),
        .cnv_code  (cnv_code),
        .res_push  (res_push),
        .res_data  (res_wdata),
        .cnv_start (cnv_start),
        .cnv_entry (cnv_entry),
        .active    (active)
    );

    assign cnv_chan     = cnv_entry.chan;
    assign cnv_gain     = cnv_entry.gain;
    assign cnv_unipolar = cnv_entry.unipolar;
    assign cnv_diff     = cnv_entry.diff;

    // register next state
    always_comb begin
        st_d           = st_q;
        st_d.half_prev = res_half;
        if (wr_ca) begin
            st_d.mode    = trig_mode_e'(bus_wdata[1:0]);
            st_d.irq_en  = bus_wdata[PEND_LSB +: NUM_SRC];
            st_d.glob_en = bus_wdata[CA_GLOBAL];
        end
        if (wr_cb) begin
            st_d.cl_en  = bus_wdata[CB_CL_EN];
            st_d.res_en = bus_wdata[CB_RES_EN];
        end
        if (res_half && !st_q.half_prev) st_d.pend[SRC_HALF] = 1'b1;
        if (cl_pop && (cl_level == CL_CW'(1))) st_d.pend[SRC_DRAIN] = 1'b1;
        if (wr_clr) st_d.pend = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    logic [15:0] status_w;
    always_comb begin
        status_w                         = '0;
        status_w[0]                      = active;
        status_w[1]                      = cl_full;
        status_w[2]                      = res_empty;
        status_w[3]                      = res_half;
        status_w[4]                      = res_full;
        status_w[PEND_LSB +: NUM_SRC]    = st_q.pend;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_STAT: bus_rdata = status_w;
            OFS_DATA: bus_rdata = res_empty ? 16'h0000 : 16'(res_rdata);
            default:  bus_rdata = 16'h0000;
        endcase
    end

    assign irq = st_q.glob_en && |(st_q.pend & st_q.irq_en);

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[14:13], cl_half, res_level};

    assert_clear_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (status_w[PEND_LSB +: NUM_SRC] == '0));

    assert_irq_needs_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.glob_en);

    assert_start_only_soft_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_start) |-> $past(st_q.mode == MODE_SOFT));

    assert_full_blocks_cl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_full && wr_cl && !cl_pop && st_q.cl_en) |=> cl_full);

endmodule

// File: tb/tb_adc_seq_front.sv
module tb_adc_seq_front;
    localparam int CLD = 4;
    localparam int RSD = 8;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, cnv_start, cnv_unipolar, cnv_diff;
    logic [3:0]  cnv_chan;
    logic [1:0]  cnv_gain;
    logic        cnv_done = 1'b0;
    logic [11:0] cnv_code = '0;

    int tests = 0;
    int fails = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    adc_seq_front #(.CL_DEPTH(CLD), .RES_DEPTH(RSD), .SAMPLE_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
        .cnv_gain(cnv_gain), .cnv_unipolar(cnv_unipolar), .cnv_diff(cnv_diff),
        .cnv_done(cnv_done), .cnv_code(cnv_code)
    );

    // converter model: code = {descriptor, 4'h3}, done LAT edges after strobe
    int cnt = 0;
    always @(posedge clk) begin
        cnv_done <= (cnt == 1);
        if (cnv_start) begin
            cnt      <= LAT;
            cnv_code <= {cnv_diff, cnv_unipolar, cnv_gain, cnv_chan, 4'h3};
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end
    end

    function automatic logic [15:0] exp_res(input logic [7:0] e);
        return {4'h0, ({e, 4'h3} ^ 12'h800)};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (LAT + 6) @(negedge clk);
    endtask

    task automatic start_conv();
        logic [15:0] d;
        brd(5'h00, d);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        brd(5'h04, d);
        chk("R1 status", d, 16'h0004);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 start", {15'd0, cnv_start}, 16'd0);
    endtask

    task automatic t_single();
        logic [15:0] d;
        bwr(5'h02, 16'h0600);
        bwr(5'h00, 16'h0001);
        bwr(5'h10, 16'h00A7);
        start_conv();
        chk("R3 strobe", {15'd0, cnv_start}, 16'd1);
        chk("R3 fields", {8'd0, cnv_diff, cnv_unipolar, cnv_gain, cnv_chan}, 16'h00A7);
        brd(5'h04, d);
        chk("R6 active", d & 16'h0001, 16'h0001);
        chk("R3 strobe one cycle", {15'd0, cnv_start}, 16'd0);
        settle();
        brd(5'h04, d);
        chk("R6 idle not empty", d & 16'h0005, 16'h0000);
        chk("R10 drain pending", d & 16'h0400, 16'h0400);
        brd(5'h10, d);
        chk("R5 msb flip", d, exp_res(8'hA7));
        brd(5'h10, d);
        chk("R5 empty read", d, 16'h0000);
        bwr(5'h04, 16'h0000);
        brd(5'h04, d);
        chk("R10 clear", d, 16'h0004);
    endtask

    task automatic t_order();
        logic [15:0] d;
        logic [7:0] e [3];
        e[0] = 8'h12; e[1] = 8'h45; e[2] = 8'h3C;
        for (int i = 0; i < 3; i++) bwr(5'h10, {8'd0, e[i]});
        for (int i = 0; i < 3; i++) begin
            start_conv();
            chk("R3 descriptor fields", {8'd0, cnv_diff, cnv_unipolar, cnv_gain, cnv_chan}, {8'd0, e[i]});
            settle();
        end
        for (int i = 0; i < 3; i++) begin
            brd(5'h10, d);
            chk("R5 order", d, exp_res(e[i]));
        end
        bwr(5'h04, 16'h0000);
    endtask

    task automatic t_ignore();
        logic [15:0] d;
        start_conv();
        chk("R4 empty list no strobe", {15'd0, cnv_start}, 16'd0);
        brd(5'h04, d);
        chk("R4 empty list idle", d & 16'h0001, 16'h0000);
        bwr(5'h10, 16'h0059);
        for (int m = 0; m < 4; m++) begin
            if (m != 1) begin
                bwr(5'h00, 16'(m));
                start_conv();
                chk("R4 mode strobe", {15'd0, cnv_start}, 16'd0);
                settle();
                brd(5'h04, d);
                chk("R4 mode idle and no result", d & 16'h0005, 16'h0004);
            end
        end
        bwr(5'h00, 16'h0001);
        start_conv();
        settle();
        brd(5'h10, d);
        chk("R4 entry kept", d, exp_res(8'h59));
        bwr(5'h04, 16'h0000);
    endtask

    task automatic t_cl_full();
        logic [15:0] d;
        for (int i = 1; i <= CLD + 1; i++) bwr(5'h10, 16'(i));
        brd(5'h04, d);
        chk("R7 full flag", d & 16'h0002, 16'h0002);
        for (int i = 0; i <= CLD; i++) begin
            start_conv();
            settle();
        end
        for (int i = 1; i <= CLD; i++) begin
            brd(5'h10, d);
            chk("R7 kept entries", d, exp_res(8'(i)));
        end
        brd(5'h10, d);
        chk("R7 extra dropped", d, 16'h0000);
        bwr(5'h04, 16'h0000);
    endtask

    task automatic t_res_full();
        logic [15:0] d;
        bwr(5'h00, 16'h8101);
        bwr(5'h04, 16'h0000);
        for (int i = 0; i < 4; i++) bwr(5'h10, 16'(i));
        for (int i = 0; i < 3; i++) begin start_conv(); settle(); end
        brd(5'h04, d);
        chk("R8 below half", d & 16'h0108, 16'h0000);
        chk("R10 irq low", {15'd0, irq}, 16'd0);
        start_conv(); settle();
        brd(5'h04, d);
        chk("R8 half", d & 16'h0118, 16'h0108);
        chk("R10 irq", {15'd0, irq}, 16'd1);
        for (int i = 4; i < 8; i++) bwr(5'h10, 16'(i));
        for (int i = 0; i < 4; i++) begin start_conv(); settle(); end
        brd(5'h04, d);
        chk("R8 full", d & 16'h0010, 16'h0010);
        bwr(5'h10, 16'h0008);
        start_conv(); settle();
        for (int i = 0; i < RSD; i++) begin
            brd(5'h10, d);
            chk("R8 stored", d, exp_res(8'(i)));
        end
        brd(5'h10, d);
        chk("R8 overflow dropped", d, 16'h0000);
        bwr(5'h04, 16'h0000);
        brd(5'h04, d);
        chk("R10 cleared", d & 16'h1F00, 16'h0000);
        chk("R10 irq cleared", {15'd0, irq}, 16'd0);
        bwr(5'h00, 16'h0001);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        bwr(5'h10, 16'h0066);
        start_conv();
        bwr(5'h00, 16'h0000);
        brd(5'h04, d);
        chk("R9 active dropped", d & 16'h0001, 16'h0000);
        settle();
        brd(5'h04, d);
        chk("R9 no result", d & 16'h0004, 16'h0004);
        bwr(5'h00, 16'h0001);
        bwr(5'h04, 16'h0000);
    endtask

    task automatic t_flush();
        logic [15:0] d;
        bwr(5'h10, 16'h0011);
        bwr(5'h02, 16'h0400);
        bwr(5'h02, 16'h0600);
        start_conv();
        chk("R2 list flushed", {15'd0, cnv_start}, 16'd0);
        bwr(5'h02, 16'h0200);
        bwr(5'h10, 16'h0022);
        start_conv();
        settle();
        bwr(5'h02, 16'h0600);
        brd(5'h04, d);
        chk("R2 result dropped", d & 16'h0004, 16'h0004);
        bwr(5'h10, 16'h0033);
        start_conv(); settle();
        bwr(5'h02, 16'h0200);
        brd(5'h04, d);
        chk("R2 result flushed", d & 16'h0004, 16'h0004);
        bwr(5'h02, 16'h0600);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_order();
        t_ignore();
        t_cl_full();
        t_res_full();
        t_abort();
        t_flush();
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule